// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is a target on a two-wire serial bus (I2C style, 7-bit addressing) that gives an external host read and write access to a bank of 8-bit control registers. The block runs on a system clock much faster than the serial clock. It passes SCL and SDA through synchronizers and recognises START, repeated START and STOP from the sampled lines. SDA is open-drain: the block never drives it high. It only asserts an enable that pulls the line low.

A write transaction carries the device address with the read/write bit clear, then one byte that loads the internal register pointer, then any number of data bytes. Each data byte is written to the register file at the pointer, and the pointer then advances. A read transaction first loads the pointer in a write phase. The host then sends a repeated START and the device address with the read/write bit set, and the block shifts out register bytes. These continue for as long as the host acknowledges them.

The register file side is a plain synchronous port. A write strobe with address and data lasts one clock. A read strobe with address lasts one clock, and the file returns data on the next clock. Neither strobe has a ready signal. The file must accept one access in any cycle, so there is no back-pressure. The serial bus itself is paced only by the host, because clock stretching is not used.

Top module: `twowire_reg_target`

## Requirements
- R1: During and directly after reset, sda_oe_o, reg_we_o and reg_re_o are all low.
- R2: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x69, so the byte is 0xD2 for a write and 0xD3 for a read). To acknowledge, it holds sda_oe_o high across the whole ninth SCL pulse. For any other address it does not pull SDA, and it ignores every later byte until a new START.
- R3: After a write address byte, the next byte is acknowledged and loaded as the register pointer.
- R4: Each data byte after the pointer byte is acknowledged. It causes a reg_we_o pulse of exactly one clock, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte, sent MSB first. The pulse occurs while SCL is low.
- R5: The pointer advances by one after each data byte of a burst. It is 8 bits wide and wraps from 0xFF to 0x00.
- R6: After a repeated START and an acknowledged read address byte, the block shifts out the register at the pointer, MSB first. sda_oe_o changes only while SCL is low.
- R7: If the host acknowledges a read byte (SDA low on the ninth pulse), the block sends the register at the next address. If the host does not acknowledge (SDA high), the block stops driving SDA until the next START. The pointer advances past every byte sent.
- R8: A STOP (SDA rising while SCL is high) at any point returns the block to idle and releases SDA. A START (SDA falling while SCL is high) at any point, including mid-byte, begins a new address byte. Neither condition writes a register.
- R9: Each byte sent is fetched by a reg_re_o pulse of exactly one clock, with the address on reg_addr_o. reg_rdata_i is taken on the following clock. reg_we_o and reg_re_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when high (open-drain) |
| reg_we_o | output | 1 | One-clock register write strobe |
| reg_re_o | output | 1 | One-clock register read strobe |
| reg_addr_o | output | 8 | Register address for the current strobe |
| reg_wdata_o | output | 8 | Write data with reg_we_o |
| reg_rdata_i | input | 8 | Read data, valid the clock after reg_re_o |

## Verification
A wrong internal state shows up at the bus within one byte. The block may acknowledge on the wrong pulse, or fail to acknowledge, so the host sees a missing or extra low on the ninth clock. A wrong bit count, or a pointer that is off, shows up at once as a write strobe to the wrong register, or in read data that is shifted or comes from the wrong address in the same byte. A missed STOP or START shows up in the next transaction, which is acknowledged when it should not be or ignored when it should be.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } twr_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_PTR,
    RX_DATA
  } twr_rx_e;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
      else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/twr_cond.sv
module twr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twr_fsm.sv
module twr_fsm
  import twr_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          reg_we,
  output logic          reg_re,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  twr_state_e    state;
  twr_rx_e       kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] ptr;
  logic          nxt_tx;
  logic          load_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= RX_DEV;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      nxt_tx    <= 1'b0;
      load_pend <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      load_pend <= reg_re;
      if (load_pend) tx_sh <= reg_rdata;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_RX;
        kind   <= RX_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt != LAST) begin
              rx_sh <= {rx_sh[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              unique case (kind)
                RX_DEV: begin
                  if (rx_sh[DW-1:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                    if (rx_sh[0]) begin
                      nxt_tx   <= 1'b1;
                      reg_re   <= 1'b1;
                      reg_addr <= ptr;
                    end else begin
                      nxt_tx <= 1'b0;
                      kind   <= RX_PTR;
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                RX_PTR: begin
                  ptr    <= rx_sh;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  nxt_tx <= 1'b0;
                  kind   <= RX_DATA;
                end
                default: begin
                  reg_we    <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= rx_sh;
                  ptr       <= ptr + 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  nxt_tx    <= 1'b0;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (nxt_tx) begin
                sda_oe <= ~tx_sh[DW-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                sda_oe <= ~tx_sh[DW-2];
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              ptr <= ptr + 1'b1;
              if (!sda_s) begin
                reg_re   <= 1'b1;
                reg_addr <= ptr + 1'b1;
                nxt_tx   <= 1'b1;
                state    <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twowire_reg_target.sv
module twowire_reg_target #(
  parameter int           DW          = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [6:0]   DEV_ADDR    = 7'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  output logic [DW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);

  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  twr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_i, sda_i}),
    .dout  (line_s)
  );

  twr_cond cond_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twr_fsm #(.DW(DW), .DEV_ADDR(DEV_ADDR[DW-2:0])) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .reg_we    (reg_we_o),
    .reg_re    (reg_re_o),
    .reg_addr  (reg_addr_o),
    .reg_wdata (reg_wdata_o),
    .reg_rdata (reg_rdata_i)
  );

endmodule

// File: rtl/twr_checker.sv
module twr_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic we,
  input logic re,
  input logic stop_det
);

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  assert_we_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !scl_i);

  assert_oe_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_re_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> !re);

  assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

bind twowire_reg_target twr_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe_o),
  .we       (reg_we_o),
  .re       (reg_re_o),
  .stop_det (stop_det)
);

// File: tb/twowire_reg_target_tb_top.sv
`timescale 1ns/1ps
module twowire_reg_target_tb_top;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic       sda_bus;
  logic       sda_oe, we, re;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] rf [256];
  logic [7:0] exp_mem [256];
  int         we_cnt = 0;
  int         re_cnt = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_h & ~sda_oe;

  twowire_reg_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_h),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_we_o    (we),
    .reg_re_o    (re),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'(i * 29 + 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= seed(i);
      rdata <= '0;
    end else begin
      if (we) begin
        rf[addr] <= wdata;
        we_cnt   <= we_cnt + 1;
      end
      if (re) begin
        rdata  <= rf[addr];
        re_cnt <= re_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; half(); scl_h = 1'b1; half(); sda_h = 1'b0; half(); scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    half(); sda_h = 1'b0; half(); scl_h = 1'b1; half(); sda_h = 1'b1; half();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      half(); sda_h = b[i]; half(); scl_h = 1'b1; half(); half(); scl_h = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    put_bits(b, 8);
    half(); sda_h = 1'b1; half(); scl_h = 1'b1; half();
    ack = int'(!sda_bus);
    half(); scl_h = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack_me);
    for (int i = 7; i >= 0; i--) begin
      half(); sda_h = 1'b1; half(); scl_h = 1'b1; half();
      b[i] = sda_bus;
      half(); scl_h = 1'b0;
    end
    half(); sda_h = !ack_me; half(); scl_h = 1'b1; half(); half(); scl_h = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int ack, base_we, base_re;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);

    repeat (4) @(negedge clk);
    chk("R1 oe in reset", int'(sda_oe), 0);
    chk("R1 we in reset", int'(we), 0);
    chk("R1 re in reset", int'(re), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", int'(sda_oe), 0);
    chk("R1 strobes after reset", int'(we | re), 0);

    // R2: sweep every 7-bit address with a write byte; a match also loads the pointer (R3)
    base_we = we_cnt;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R2 address ack", ack, int'(a == 'h69));
      send_byte(8'hD2, ack);
      chk("R2 follow-on byte", ack, int'(a == 'h69));
      bus_stop();
    end
    chk("R2 no writes during sweep", we_cnt - base_we, 0);

    // R3/R4: burst write from 0x10
    base_we = we_cnt;
    bus_start();
    send_byte(8'hD2, ack); chk("R3 dev ack", ack, 1);
    send_byte(8'h10, ack); chk("R3 pointer ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(k * 37 + 11), ack);
      chk("R4 data ack", ack, 1);
      exp_mem[8'h10 + k] = 8'(k * 37 + 11);
    end
    bus_stop();
    chk("R4 one strobe per byte", we_cnt - base_we, 4);
    for (int k = 0; k < 4; k++) chk("R4 written value", int'(rf[8'h10 + k]), int'(exp_mem[8'h10 + k]));

    // R5: wrap across 0xFF
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hFE, ack);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'hC0 + k), ack);
      exp_mem[8'(8'hFE + k)] = 8'(8'hC0 + k);
    end
    bus_stop();
    chk("R5 wrap 0xFE", int'(rf[8'hFE]), 'hC0);
    chk("R5 wrap 0xFF", int'(rf[8'hFF]), 'hC1);
    chk("R5 wrap 0x00", int'(rf[8'h00]), 'hC2);
    chk("R5 wrap 0x01", int'(rf[8'h01]), 'hC3);

    // R6/R7/R9: reads of three bytes from a spread of pointers
    for (int p = 0; p < 256; p += 23) begin
      base_re = re_cnt;
      bus_start();
      send_byte(8'hD2, ack);
      send_byte(8'(p), ack);
      bus_start();
      send_byte(8'hD3, ack); chk("R6 read address ack", ack, 1);
      recv_byte(b, 1'b1); chk("R6 first byte", int'(b), int'(exp_mem[8'(p)]));
      recv_byte(b, 1'b1); chk("R7 second byte", int'(b), int'(exp_mem[8'(p + 1)]));
      recv_byte(b, 1'b0); chk("R7 third byte", int'(b), int'(exp_mem[8'(p + 2)]));
      recv_byte(b, 1'b0); chk("R7 released after nack", int'(b), 'hFF);
      bus_stop();
      chk("R9 one fetch per byte sent", re_cnt - base_re, 3);
    end

    // R7: pointer sits past the last byte read; plain read continues there
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(b, 1'b0);
    bus_stop();
    chk("R7 pointer advanced past read", int'(b), int'(exp_mem[8'(253 + 3)]));

    // R8: STOP mid-byte returns to idle without writing
    base_we = we_cnt;
    bus_start();
    send_byte(8'hD2, ack);
    put_bits(8'h40, 4);
    bus_stop();
    send_byte(8'hD2, ack);
    chk("R8 idle after stop ignores address", ack, 0);
    chk("R8 no write on aborted byte", we_cnt - base_we, 0);
    chk("R8 bus released", int'(sda_oe), 0);

    // R8: START mid-byte begins a fresh address byte
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h40, ack);
    put_bits(8'hFF, 3);
    bus_start();
    send_byte(8'hD2, ack); chk("R8 restart address ack", ack, 1);
    send_byte(8'h41, ack);
    send_byte(8'h99, ack); chk("R8 data after restart", ack, 1);
    bus_stop();
    chk("R8 write after restart", int'(rf[8'h41]), 'h99);
    chk("R8 no write from aborted byte", int'(rf[8'h40]), int'(exp_mem[8'h40]));

    done = 1'b1;
    finish_run();
  end

endmodule